// File: doc/BRIEF.md
# User-Mode Fault Detector with Cause Registers

This block looks at the attributes of one user-mode instruction, already decoded elsewhere, and decides whether the instruction faults. When it does, the block raises a one-cycle exception strobe and loads a small set of cause registers that a privileged handler reads afterwards. Those registers hold the faulting fetch address, a two-bit cause code, the logical page that missed, and the logical address that broke a bound or a protection rule.

The instruction decoder supplies the following each time it presents an instruction with `chk_vld_i`:

- the operation class;
- flags for constant destination, disallowed register or port access, and malformed encoding;
- the software-interrupt number;
- the memory-operand address and its direction;
- the stack pointer and the jump target;
- the divisor;
- the page-table valid and write bits of the referenced page;
- the page-table length;
- the fetch address.

Exactly one cause is recorded per fault, chosen by a fixed priority.

Top module: `exc_cause_regs`

## Requirements
- R1: After reset `exc_o` is 0 and `eip_o`, `epn_o`, `ec_o`, `ema_o` are all 0.
- R2: `op_cls_i` encodes 0 plain, 1 pop/return, 2 push/call/hardware entry, 3 jump, 4 divide/modulo, 5 software interrupt, 6 privileged-only instruction. When `chk_vld_i` is high and a fault exists, `exc_o` is 1 in the following cycle and `eip_o` then holds that cycle's `fetch_ip_i`. With no fault, or with `chk_vld_i` low, `exc_o` stays 0.
- R3: An illegal-instruction fault (EC=1) is raised by `dst_const_i`, `priv_acc_i` or `bad_form_i` high, or by class 6.
- R4: Class 5 with `int_num_i` below 4 or above 18 is an illegal-instruction fault. Numbers 4 through 18 are accepted.
- R5: With the bound L = `ptlr_i`*512, a memory operand (`mem_use_i`=1) or a class-3 jump target outside 0..L-1 (addresses are two's complement) is an illegal memory access (EC=2), and `ema_o` receives that address.
- R6: Class 1 needs SP in 0..L-1. Classes 2 and 5 need SP in -1..L-2. A violation gives EC=2, with `ema_o` set to SP for class 1 and to SP+1 for classes 2 and 5.
- R7: A write to the referenced page while `pte_wr_i` is 0 gives EC=2 with `ema_o` set to the referenced address. The referenced address is the memory operand (writing when `wr_acc_i`=1) or else the stack slot (a write for classes 2 and 5).
- R8: Class 4 with `divisor_i` equal to 0 gives EC=3.
- R9: When an address is referenced, no other fault applies and `pte_vld_i` is 0, the block raises a page fault (EC=0) and `epn_o` receives the referenced address divided by 512.
- R10: When several faults hit together, the priority is EC=1, then EC=2, then EC=3, then EC=0.
- R11: `epn_o` changes only on a page fault and `ema_o` only on EC=2. Without an exception, all four registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_vld_i | input | 1 | An instruction is presented for checking |
| op_cls_i | input | 3 | Operation class (R2 encoding) |
| dst_const_i | input | 1 | Move targets a constant |
| priv_acc_i | input | 1 | Register or port not allowed in user mode |
| bad_form_i | input | 1 | Unknown opcode or wrong operand count |
| int_num_i | input | 8 | Software-interrupt number |
| mem_use_i | input | 1 | Instruction has a memory operand |
| wr_acc_i | input | 1 | Memory operand is written |
| mem_addr_i | input | 16 | Logical address of the memory operand |
| sp_i | input | 16 | Stack pointer before the operation |
| jmp_tgt_i | input | 16 | Jump target |
| divisor_i | input | 16 | Second operand of divide/modulo |
| pte_vld_i | input | 1 | Valid bit of the referenced page |
| pte_wr_i | input | 1 | Write-permission bit of the referenced page |
| ptlr_i | input | 8 | Page-table length in pages |
| fetch_ip_i | input | 16 | Address the instruction was fetched from |
| exc_o | output | 1 | One-cycle exception strobe |
| eip_o | output | 16 | Fetch address of the faulting instruction |
| epn_o | output | 7 | Logical page of the last page fault |
| ec_o | output | 2 | Cause code |
| ema_o | output | 16 | Offending logical address of the last EC=2 fault |

## Verification
Each operation class is tried just inside and just outside its bound:

- address L-1 against L, and negative addresses;
- SP of -1 for pop against push, and L-2 against L-1 for push;
- interrupt numbers 3, 4, 18 and 19;
- divisor 0 against a non-zero divisor.

These pairs tell apart off-by-one errors and mixed-up stack bounds. Combined patterns, where two or more faults hit in one instruction, separate correct cause priority from a wrong order. Sequences of unlike faults show whether `epn_o` and `ema_o` wrongly follow a cause that does not define them.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        EC_PFAULT = 2'd0,
        EC_ILLINS = 2'd1,
        EC_ILLMEM = 2'd2,
        EC_ARITH  = 2'd3
    } ec_e;

    typedef enum logic [2:0] {
        OP_PLAIN = 3'd0,
        OP_POP   = 3'd1,
        OP_PUSH  = 3'd2,
        OP_JUMP  = 3'd3,
        OP_DIV   = 3'd4,
        OP_INT   = 3'd5,
        OP_PRIV  = 3'd6
    } op_e;

endpackage

// File: rtl/exc_range_chk.sv
// Tells whether a two's-complement logical address lies in 0 .. limit-1.
module exc_range_chk #(
    parameter int W  = 16,
    parameter int LW = 17
) (
    input  logic [W-1:0]  addr_i,
    input  logic [LW-1:0] limit_i,
    output logic          ok_o
);
    localparam int CW = ((W > LW) ? W : LW) + 1;

    logic [CW-1:0] a_ext;
    logic [CW-1:0] l_ext;

    always_comb begin
        a_ext = CW'(addr_i);
        l_ext = CW'(limit_i);
        ok_o  = !addr_i[W-1] && (a_ext < l_ext);
    end
endmodule

// File: rtl/exc_fault_eval.sv
// Combinational evaluation of every fault source for one instruction.
module exc_fault_eval
    import exc_pkg::*;
#(
    parameter int W      = 16,
    parameter int PT_W   = 8,
    parameter int PG_LOG = 9,
    parameter int NUM_W  = 8,
    parameter int INT_LO = 4,
    parameter int INT_HI = 18
) (
    input  logic [2:0]         op_cls_i,
    input  logic               dst_const_i,
    input  logic               priv_acc_i,
    input  logic               bad_form_i,
    input  logic [NUM_W-1:0]   int_num_i,
    input  logic               mem_use_i,
    input  logic               wr_acc_i,
    input  logic [W-1:0]       mem_addr_i,
    input  logic [W-1:0]       sp_i,
    input  logic [W-1:0]       jmp_tgt_i,
    input  logic [W-1:0]       divisor_i,
    input  logic               pte_vld_i,
    input  logic               pte_wr_i,
    input  logic [PT_W-1:0]    ptlr_i,
    output logic               ill_hit_o,
    output logic               mem_hit_o,
    output logic               ari_hit_o,
    output logic               pf_hit_o,
    output logic [W-1:0]       bad_addr_o,
    output logic [W-PG_LOG-1:0] ref_page_o
);
    localparam int LW   = PT_W + PG_LOG;
    localparam int NCHK = 3;   // 0: memory operand, 1: jump target, 2: stack slot

    logic [LW-1:0] limit;
    logic [W-1:0]  stk_addr;
    logic [W-1:0]  ref_addr;
    logic [W-1:0]  chk_addr [NCHK];
    logic [NCHK-1:0] in_rng;
    logic is_pop, is_push, stk_use, ref_use, ref_wr;
    logic mem_bad, jmp_bad, stk_bad, wp_bad, int_bad;

    assign limit = LW'(ptlr_i) << PG_LOG;

    always_comb begin
        is_pop   = (op_cls_i == OP_POP);
        is_push  = (op_cls_i == OP_PUSH) || (op_cls_i == OP_INT);
        stk_use  = is_pop || is_push;
        stk_addr = is_pop ? sp_i : (sp_i + W'(1));
        chk_addr[0] = mem_addr_i;
        chk_addr[1] = jmp_tgt_i;
        chk_addr[2] = stk_addr;
    end

    for (genvar g = 0; g < NCHK; g++) begin : g_rng
        exc_range_chk #(.W(W), .LW(LW)) u_rng (
            .addr_i  (chk_addr[g]),
            .limit_i (limit),
            .ok_o    (in_rng[g])
        );
    end

    always_comb begin
        int_bad  = (op_cls_i == OP_INT) &&
                   ((int_num_i < NUM_W'(INT_LO)) || (int_num_i > NUM_W'(INT_HI)));
        ill_hit_o = dst_const_i || priv_acc_i || bad_form_i ||
                    (op_cls_i == OP_PRIV) || int_bad;

        mem_bad  = mem_use_i && !in_rng[0];
        jmp_bad  = (op_cls_i == OP_JUMP) && !in_rng[1];
        stk_bad  = stk_use && !in_rng[2];
        ref_use  = mem_use_i || stk_use;
        ref_addr = mem_use_i ? mem_addr_i : stk_addr;
        ref_wr   = mem_use_i ? wr_acc_i : is_push;
        wp_bad   = ref_use && ref_wr && !pte_wr_i;

        mem_hit_o = mem_bad || jmp_bad || stk_bad || wp_bad;
        if (mem_bad)      bad_addr_o = mem_addr_i;
        else if (stk_bad) bad_addr_o = stk_addr;
        else if (jmp_bad) bad_addr_o = jmp_tgt_i;
        else              bad_addr_o = ref_addr;

        ari_hit_o  = (op_cls_i == OP_DIV) && (divisor_i == '0);
        pf_hit_o   = ref_use && !pte_vld_i;
        ref_page_o = ref_addr[W-1:PG_LOG];
    end
endmodule

// File: rtl/exc_cause_regs.sv
// Fault priority selection and cause-register state.
module exc_cause_regs
    import exc_pkg::*;
#(
    parameter int W      = 16,
    parameter int PT_W   = 8,
    parameter int PG_LOG = 9,
    parameter int NUM_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_vld_i,
    input  logic [2:0]         op_cls_i,
    input  logic               dst_const_i,
    input  logic               priv_acc_i,
    input  logic               bad_form_i,
    input  logic [NUM_W-1:0]   int_num_i,
    input  logic               mem_use_i,
    input  logic               wr_acc_i,
    input  logic [W-1:0]       mem_addr_i,
    input  logic [W-1:0]       sp_i,
    input  logic [W-1:0]       jmp_tgt_i,
    input  logic [W-1:0]       divisor_i,
    input  logic               pte_vld_i,
    input  logic               pte_wr_i,
    input  logic [PT_W-1:0]    ptlr_i,
    input  logic [W-1:0]       fetch_ip_i,
    output logic               exc_o,
    output logic [W-1:0]       eip_o,
    output logic [W-PG_LOG-1:0] epn_o,
    output logic [1:0]         ec_o,
    output logic [W-1:0]       ema_o
);
    localparam int PN_W = W - PG_LOG;

    typedef struct packed {
        logic            exc;
        logic [W-1:0]    eip;
        logic [PN_W-1:0] epn;
        ec_e             ec;
        logic [W-1:0]    ema;
    } st_t;

    st_t st_d, st_q;
    logic ill_hit, mem_hit, ari_hit, pf_hit;
    logic [W-1:0]    bad_addr;
    logic [PN_W-1:0] ref_page;

    exc_fault_eval #(
        .W(W), .PT_W(PT_W), .PG_LOG(PG_LOG), .NUM_W(NUM_W),
        .INT_LO(4), .INT_HI(18)
    ) u_eval (
        .op_cls_i    (op_cls_i),
        .dst_const_i (dst_const_i),
        .priv_acc_i  (priv_acc_i),
        .bad_form_i  (bad_form_i),
        .int_num_i   (int_num_i),
        .mem_use_i   (mem_use_i),
        .wr_acc_i    (wr_acc_i),
        .mem_addr_i  (mem_addr_i),
        .sp_i        (sp_i),
        .jmp_tgt_i   (jmp_tgt_i),
        .divisor_i   (divisor_i),
        .pte_vld_i   (pte_vld_i),
        .pte_wr_i    (pte_wr_i),
        .ptlr_i      (ptlr_i),
        .ill_hit_o   (ill_hit),
        .mem_hit_o   (mem_hit),
        .ari_hit_o   (ari_hit),
        .pf_hit_o    (pf_hit),
        .bad_addr_o  (bad_addr),
        .ref_page_o  (ref_page)
    );

    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        if (chk_vld_i && (ill_hit || mem_hit || ari_hit || pf_hit)) begin
            st_d.exc = 1'b1;
            st_d.eip = fetch_ip_i;
            if (ill_hit) begin
                st_d.ec = EC_ILLINS;
            end else if (mem_hit) begin
                st_d.ec  = EC_ILLMEM;
                st_d.ema = bad_addr;
            end else if (ari_hit) begin
                st_d.ec = EC_ARITH;
            end else begin
                st_d.ec  = EC_PFAULT;
                st_d.epn = ref_page;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_o = st_q.exc;
    assign eip_o = st_q.eip;
    assign epn_o = st_q.epn;
    assign ec_o  = st_q.ec;
    assign ema_o = st_q.ema;

    AST_EXC_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> $past(chk_vld_i)); // R2
    AST_EIP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (eip_o == $past(fetch_ip_i))); // R2
    AST_ILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_i && ill_hit) |=> (exc_o && ec_o == EC_ILLINS)); // R10
    AST_PF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && ec_o == EC_PFAULT) |-> $past(!ill_hit && !mem_hit && !ari_hit && pf_hit)); // R9
    AST_EPN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_o && ec_o == EC_PFAULT) |-> $stable(epn_o)); // R11
    AST_EMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_o && ec_o == EC_ILLMEM) |-> $stable(ema_o)); // R11
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_o |-> ($stable(eip_o) && $stable(ec_o))); // R11
endmodule

// File: tb/sim_exc_cause_regs.sv
module sim_exc_cause_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_vld_i, dst_const_i, priv_acc_i, bad_form_i, mem_use_i, wr_acc_i;
    logic pte_vld_i, pte_wr_i;
    logic [2:0]  op_cls_i;
    logic [7:0]  int_num_i, ptlr_i;
    logic [15:0] mem_addr_i, sp_i, jmp_tgt_i, divisor_i, fetch_ip_i;
    logic        exc_o;
    logic [15:0] eip_o, ema_o;
    logic [6:0]  epn_o;
    logic [1:0]  ec_o;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] e_eip = '0, e_ema = '0;
    logic [6:0]  e_epn = '0;
    logic [1:0]  e_ec = '0;
    logic [15:0] ip_ctr = 16'h0040;

    always #2 clk = ~clk;

    exc_cause_regs u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        chk_vld_i = 0; dst_const_i = 0; priv_acc_i = 0; bad_form_i = 0;
        mem_use_i = 0; wr_acc_i = 0; pte_vld_i = 1; pte_wr_i = 1;
        op_cls_i = 3'd0; int_num_i = 8'd5; ptlr_i = 8'd10;
        mem_addr_i = 16'd100; sp_i = 16'd100; jmp_tgt_i = 16'd0;
        divisor_i = 16'd1;
    endtask

    // Present the staged instruction for one cycle and compare all outputs.
    // fault: 1 means expected exception with cause ec; updates e_* model.
    task automatic fire(input string tag, input bit fault, input logic [1:0] ec,
                        input bit set_ema, input logic [15:0] ema,
                        input bit set_epn, input logic [6:0] epn, input bit vld = 1);
        ip_ctr     = ip_ctr + 16'd2;
        fetch_ip_i = ip_ctr;
        chk_vld_i  = vld;
        @(negedge clk);
        chk_vld_i = 0;
        if (fault) begin
            e_eip = ip_ctr; e_ec = ec;
            if (set_ema) e_ema = ema;
            if (set_epn) e_epn = epn;
        end
        chk({tag, " exc"}, 16'(exc_o), 16'(fault));
        chk({tag, " eip"}, eip_o, e_eip);
        chk({tag, " ec"},  16'(ec_o), 16'(e_ec));
        chk({tag, " ema"}, ema_o, e_ema);
        chk({tag, " epn"}, 16'(epn_o), 16'(e_epn));
        clr();
    endtask

    task automatic t_reset();
        chk("R1 exc", 16'(exc_o), 16'd0);
        chk("R1 eip", eip_o, 16'd0);
        chk("R1 ec", 16'(ec_o), 16'd0);
        chk("R1 ema", ema_o, 16'd0);
        chk("R1 epn", 16'(epn_o), 16'd0);
    endtask

    task automatic t_clean();
        mem_use_i = 1; mem_addr_i = 16'd5119;
        fire("R2 clean load", 0, 0, 0, 0, 0, 0);
        dst_const_i = 1;
        fire("R2 no vld", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_illegal();
        dst_const_i = 1; fire("R3 const dst", 1, 2'd1, 0, 0, 0, 0);
        priv_acc_i = 1;  fire("R3 priv reg", 1, 2'd1, 0, 0, 0, 0);
        bad_form_i = 1;  fire("R3 bad form", 1, 2'd1, 0, 0, 0, 0);
        op_cls_i = 3'd6; fire("R3 priv op", 1, 2'd1, 0, 0, 0, 0);
    endtask

    task automatic t_int();
        op_cls_i = 3'd5; int_num_i = 8'd3;  fire("R4 int3", 1, 2'd1, 0, 0, 0, 0);
        op_cls_i = 3'd5; int_num_i = 8'd19; fire("R4 int19", 1, 2'd1, 0, 0, 0, 0);
        op_cls_i = 3'd5; int_num_i = 8'd4;  fire("R4 int4", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd5; int_num_i = 8'd18; fire("R4 int18", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mem();
        mem_use_i = 1; mem_addr_i = 16'd5120;
        fire("R5 load at L", 1, 2'd2, 1, 16'd5120, 0, 0);
        mem_use_i = 1; mem_addr_i = 16'hFFFE;
        fire("R5 load neg", 1, 2'd2, 1, 16'hFFFE, 0, 0);
        op_cls_i = 3'd3; jmp_tgt_i = 16'd5119;
        fire("R5 jump L-1", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd3; jmp_tgt_i = 16'hFFFF;
        fire("R5 jump neg", 1, 2'd2, 1, 16'hFFFF, 0, 0);
    endtask

    task automatic t_sp();
        op_cls_i = 3'd1; sp_i = 16'hFFFF; fire("R6 pop -1", 1, 2'd2, 1, 16'hFFFF, 0, 0);
        op_cls_i = 3'd1; sp_i = 16'd0;    fire("R6 pop 0", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd1; sp_i = 16'd5120; fire("R6 pop L", 1, 2'd2, 1, 16'd5120, 0, 0);
        op_cls_i = 3'd2; sp_i = 16'hFFFF; fire("R6 push -1", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd2; sp_i = 16'd5118; fire("R6 push L-2", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd2; sp_i = 16'd5119; fire("R6 push L-1", 1, 2'd2, 1, 16'd5120, 0, 0);
        op_cls_i = 3'd5; sp_i = 16'd5119; fire("R6 int L-1", 1, 2'd2, 1, 16'd5120, 0, 0);
    endtask

    task automatic t_wprot();
        mem_use_i = 1; wr_acc_i = 1; pte_wr_i = 0; mem_addr_i = 16'd600;
        fire("R7 store ro", 1, 2'd2, 1, 16'd600, 0, 0);
        mem_use_i = 1; wr_acc_i = 0; pte_wr_i = 0; mem_addr_i = 16'd700;
        fire("R7 load ro", 0, 0, 0, 0, 0, 0);
        op_cls_i = 3'd2; pte_wr_i = 0; sp_i = 16'd800;
        fire("R7 push ro", 1, 2'd2, 1, 16'd801, 0, 0);
    endtask

    task automatic t_div();
        op_cls_i = 3'd4; divisor_i = 16'd0; fire("R8 div0 R11 ema hold", 1, 2'd3, 0, 0, 0, 0);
        op_cls_i = 3'd4; divisor_i = 16'd5; fire("R8 div5", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_pf();
        mem_use_i = 1; mem_addr_i = 16'd1500; pte_vld_i = 0;
        fire("R9 load pf R11 ema hold", 1, 2'd0, 0, 0, 1, 7'd2);
        op_cls_i = 3'd2; sp_i = 16'd4607; pte_vld_i = 0;
        fire("R9 push pf", 1, 2'd0, 0, 0, 1, 7'd9);
        dst_const_i = 1; fire("R11 epn hold", 1, 2'd1, 0, 0, 0, 0);
    endtask

    task automatic t_prio();
        dst_const_i = 1; op_cls_i = 3'd4; divisor_i = 0; mem_use_i = 1;
        mem_addr_i = 16'd9000; pte_vld_i = 0;
        fire("R10 ill over all", 1, 2'd1, 0, 0, 0, 0);
        op_cls_i = 3'd4; divisor_i = 0; mem_use_i = 1; mem_addr_i = 16'd9000;
        fire("R10 mem over div", 1, 2'd2, 1, 16'd9000, 0, 0);
        op_cls_i = 3'd4; divisor_i = 0; mem_use_i = 1; mem_addr_i = 16'd1100; pte_vld_i = 0;
        fire("R10 div over pf", 1, 2'd3, 0, 0, 0, 0);
        mem_use_i = 1; mem_addr_i = 16'd2000; wr_acc_i = 1; pte_wr_i = 0; pte_vld_i = 0;
        fire("R10 wprot over pf", 1, 2'd2, 1, 16'd2000, 0, 0);
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clr();
        fetch_ip_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_illegal();
        t_int();
        t_mem();
        t_sp();
        t_wprot();
        t_div();
        t_pf();
        t_prio();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule